// File: doc/BRIEF.md
# Palette Host Access Sequencer

This block is the host-facing register port of a 256-entry colour table whose entries hold 6 bits each of red, green and blue. A host reaches the table one byte at a time through a small synchronous register port: a register select, separate write and read strobes, and 8-bit data in each direction. Loading the index through one of two address registers chooses the direction of the transfers that follow. Three data-port accesses then move one table entry in red, green, blue order. After each full entry the index steps by one on its own, so a long burst of bytes covers consecutive entries.

The block also holds a pixel mask register for the video side, driven out on its own port, and a status byte that tells software which direction is selected. All host accesses take effect on the rising clock edge where a strobe is high. Read data is combinational while the read strobe is high. The host raises at most one strobe per cycle. If both are high, the write acts and the read has no side effect.

Top module: `palette_host_seq`

## Requirements
- R1: A write to select 0x8 loads the index register with the written byte, selects write direction and clears the byte phase.
- R2: A write to select 0x7 loads the index register, selects read direction, copies the entry at that index into the staging register, leaves the index at the written value plus one and clears the byte phase.
- R3: In write direction, three writes to select 0x9 supply red, green and blue, keeping bits 5:0 of each byte. The third write stores the 18-bit entry at the current index and the index then steps by one.
- R4: In read direction, three reads of select 0x9 return red, green and blue of the staged entry in bits 5:0, with bits 7:6 zero. The third read copies the entry at the current index into staging and the index steps by one.
- R5: Every index step wraps from 255 to 0.
- R6: A write to select 0x7 or 0x8 in the middle of a three-byte transfer abandons it: the table is not updated and the new direction starts at byte phase 0 (red).
- R7: Reading select 0x7 returns 0x03 in write direction and 0x00 in read direction. Reads of select 0x7 or 0x8 change neither the index, the phase nor the staging.
- R8: Reading select 0x8 returns the current index register.
- R9: Select 0x6 is a read/write pixel mask that resets to 0xFF and is driven continuously on `pix_mask`.
- R10: A data write in read direction, or a data read in write direction, is ignored: the table, index and phase are unchanged, and such a read returns 0x00.
- R11: After reset the block is in write direction with index 0 and byte phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 4 | Register select (0x6 mask, 0x7 read index/status, 0x8 write index, 0x9 data) |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| pix_mask | output | 8 | Pixel mask value |

## Verification
The bench goes after the index wrap at 255. A design without the wrap would leave the index stuck or out of range, and the readback of select 0x8 would differ. It rewrites the index after one or two data bytes. A design that kept the old phase would put green into the red field, or write a partial entry. It makes data accesses in the wrong direction, which a careless design would let step the phase or corrupt an entry, so that the following bytes shift. It writes full 8-bit values and expects bits 7:6 to read back as zero. It also interleaves status and index reads in the middle of transfers, which would expose a read that moves the phase.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam logic [3:0]  SEL_MASK  = 4'h6;
  localparam logic [3:0]  SEL_RIDX  = 4'h7;
  localparam logic [3:0]  SEL_WIDX  = 4'h8;
  localparam logic [3:0]  SEL_DATA  = 4'h9;
  localparam int unsigned N_CHAN    = 3;

  typedef enum logic {
    MODE_WR = 1'b0,
    MODE_RD = 1'b1
  } pal_mode_e;
endpackage

// File: rtl/pal_seq_ctrl.sv
module pal_seq_ctrl
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_widx,
  input  logic             ld_ridx,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             data_wr,
  input  logic             data_rd,
  output pal_mode_e        mode,
  output logic [1:0]       phase,
  output logic [IDX_W-1:0] idx,
  output logic             cap_en,
  output logic             tab_we,
  output logic             fetch,
  output logic [IDX_W-1:0] fetch_idx
);
  localparam logic [1:0] LAST_PH = 2'(N_CHAN - 1);

  pal_mode_e        mode_q, mode_d;
  logic [1:0]       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             acc_wr, acc_rd, step, last, state_en;

  assign acc_wr   = data_wr && (mode_q == MODE_WR);
  assign acc_rd   = data_rd && (mode_q == MODE_RD);
  assign step     = acc_wr || acc_rd;
  assign last     = (phase_q == LAST_PH);
  assign state_en = ld_widx || ld_ridx || step;

  assign cap_en    = acc_wr && !ld_widx && !ld_ridx;
  assign tab_we    = cap_en && last;
  assign fetch     = ld_ridx || (acc_rd && last && !ld_widx);
  assign fetch_idx = ld_ridx ? ld_val : idx_q;

  always_comb begin
    mode_d  = mode_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    if (ld_widx) begin
      mode_d  = MODE_WR;
      phase_d = 2'd0;
      idx_d   = ld_val;
    end else if (ld_ridx) begin
      mode_d  = MODE_RD;
      phase_d = 2'd0;
      idx_d   = ld_val + 1'b1;
    end else if (step) begin
      if (last) begin
        phase_d = 2'd0;
        idx_d   = idx_q + 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_WR;
      phase_q <= 2'd0;
      idx_q   <= '0;
    end else if (state_en) begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign mode  = mode_q;
  assign phase = phase_q;
  assign idx   = idx_q;

  // R11
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  // R6
  abort_phase_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_widx || ld_ridx) |=> (phase_q == 2'd0));

  // R1
  widx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_widx |=> (mode_q == MODE_WR) && (idx_q == $past(ld_val)));

  // R2
  ridx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ridx && !ld_widx) |=> (mode_q == MODE_RD) && (idx_q == IDX_W'($past(ld_val) + 1'b1)));

  // R3
  store_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tab_we |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (phase_q == 2'd0));
endmodule

// File: rtl/pal_stage.sv
module pal_stage
  import pal_pkg::*;
#(
  parameter int unsigned CH_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic [1:0]             cap_phase,
  input  logic [CH_W-1:0]        cap_byte,
  input  logic                   load_en,
  input  logic [N_CHAN*CH_W-1:0] load_val,
  input  logic [1:0]             rd_phase,
  output logic [N_CHAN*CH_W-1:0] wr_word,
  output logic [CH_W-1:0]        rd_ch
);
  logic [CH_W-1:0] ch_q [N_CHAN];
  logic [CH_W-1:0] ch_d [N_CHAN];
  logic            st_en;

  assign st_en = load_en || cap_en;

  always_comb begin
    for (int c = 0; c < N_CHAN; c++) begin
      ch_d[c] = ch_q[c];
      if (load_en)
        ch_d[c] = load_val[(N_CHAN-c)*CH_W-1 -: CH_W];
      else if (cap_en && (cap_phase == 2'(c)))
        ch_d[c] = cap_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CHAN; c++) ch_q[c] <= '0;
    end else if (st_en) begin
      for (int c = 0; c < N_CHAN; c++) ch_q[c] <= ch_d[c];
    end
  end

  // red and green come from staging, blue straight from the third byte
  assign wr_word = {ch_q[0], ch_q[1], cap_byte};

  always_comb begin
    case (rd_phase)
      2'd0:    rd_ch = ch_q[0];
      2'd1:    rd_ch = ch_q[1];
      2'd2:    rd_ch = ch_q[2];
      default: rd_ch = '0;
    endcase
  end

  // R2
  no_cap_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && cap_en));
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 18
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [ENT_W-1:0] wval,
  input  logic [IDX_W-1:0] ridx,
  output logic [ENT_W-1:0] rval
);
  localparam int unsigned DEPTH = 2 ** IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wval;
  end

  assign rval = mem[ridx];
endmodule

// File: rtl/palette_host_seq.sv
module palette_host_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CH_W   = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] pix_mask
);
  localparam int unsigned ENT_W = N_CHAN * CH_W;

  logic              ld_widx, ld_ridx, data_wr, data_rd, mask_wr;
  pal_mode_e         mode;
  logic [1:0]        phase;
  logic [IDX_W-1:0]  idx, fetch_idx;
  logic              cap_en, tab_we, fetch;
  logic [ENT_W-1:0]  wr_word, rd_word;
  logic [CH_W-1:0]   rd_ch;
  logic [DATA_W-1:0] mask_q;

  assign ld_widx = host_wr && (host_sel == SEL_WIDX);
  assign ld_ridx = host_wr && (host_sel == SEL_RIDX);
  assign data_wr = host_wr && (host_sel == SEL_DATA);
  assign mask_wr = host_wr && (host_sel == SEL_MASK);
  assign data_rd = host_rd && !host_wr && (host_sel == SEL_DATA);

  pal_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_widx   (ld_widx),
    .ld_ridx   (ld_ridx),
    .ld_val    (host_wdata[IDX_W-1:0]),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .mode      (mode),
    .phase     (phase),
    .idx       (idx),
    .cap_en    (cap_en),
    .tab_we    (tab_we),
    .fetch     (fetch),
    .fetch_idx (fetch_idx)
  );

  pal_stage #(.CH_W(CH_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .cap_phase (phase),
    .cap_byte  (host_wdata[CH_W-1:0]),
    .load_en   (fetch),
    .load_val  (rd_word),
    .rd_phase  (phase),
    .wr_word   (wr_word),
    .rd_ch     (rd_ch)
  );

  pal_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
    .clk  (clk),
    .we   (tab_we),
    .widx (idx),
    .wval (wr_word),
    .ridx (fetch_idx),
    .rval (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= host_wdata;
  end

  assign pix_mask = mask_q;

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_sel)
        SEL_MASK: host_rdata = mask_q;
        SEL_RIDX: host_rdata = (mode == MODE_WR) ? DATA_W'(2'b11) : '0;
        SEL_WIDX: host_rdata = DATA_W'(idx);
        SEL_DATA: host_rdata = (mode == MODE_RD) ? DATA_W'(rd_ch) : '0;
        default:  host_rdata = '0;
      endcase
    end
  end

  // R10
  wrong_dir_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (mode == MODE_RD)) |=> $stable(idx) && $stable(phase));

  // R10
  wrong_dir_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && (mode == MODE_WR) && !host_wr) |=> $stable(idx) && $stable(phase));

  // R7
  status_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && (host_sel != SEL_DATA)) |=> $stable(idx) && $stable(phase) && $stable(mode));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(pix_mask));
endmodule

// File: tb/palette_host_seq_bench.sv
`timescale 1ns/1ps
module palette_host_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] host_sel;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [7:0] pix_mask;

  always #2 clk = ~clk;

  palette_host_seq u_palette_host_seq (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_mask(pix_mask)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference state built from the requirements
  logic [17:0] m_tab [256];
  bit          m_rd;
  logic [7:0]  m_idx;
  int          m_ph;
  logic [5:0]  m_st [3];
  logic [7:0]  m_mask;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] s);
    case (s)
      4'h6: return m_mask;
      4'h7: return m_rd ? 8'h00 : 8'h03;
      4'h8: return m_idx;
      4'h9: return m_rd ? {2'b00, m_st[m_ph]} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] s);
    case (s)
      4'h6: return "R9 mask read";
      4'h7: return "R7 status read";
      4'h8: return "R8 index read";
      default: return m_rd ? "R4 data read" : "R10 wrong-direction read";
    endcase
  endfunction

  task automatic load_stage(input logic [7:0] i);
    m_st[0] = m_tab[i][17:12];
    m_st[1] = m_tab[i][11:6];
    m_st[2] = m_tab[i][5:0];
  endtask

  task automatic host_write(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
    @(posedge clk);
    case (s)
      4'h6: m_mask = d;
      4'h7: begin m_rd = 1'b1; m_ph = 0; load_stage(d); m_idx = d + 8'd1; end
      4'h8: begin m_rd = 1'b0; m_ph = 0; m_idx = d; end
      4'h9: if (!m_rd) begin
        m_st[m_ph] = d[5:0];
        if (m_ph == 2) begin
          m_tab[m_idx] = {m_st[0], m_st[1], m_st[2]};
          m_idx = m_idx + 8'd1; m_ph = 0;
        end else m_ph++;
      end
      default: ;
    endcase
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] s);
    @(negedge clk);
    host_sel = s; host_wr = 1'b0; host_rd = 1'b1;
    #1;
    check(rd_tag(s), host_rdata, exp_rd(s));
    @(posedge clk);
    if (s == 4'h9 && m_rd) begin
      if (m_ph == 2) begin
        load_stage(m_idx); m_idx = m_idx + 8'd1; m_ph = 0;
      end else m_ph++;
    end
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    host_sel = 4'h0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    rst_n = 1'b0;
    m_rd = 1'b0; m_idx = 8'h00; m_ph = 0; m_mask = 8'hFF;
    for (int c = 0; c < 3; c++) m_st[c] = 6'h00;
    for (int i = 0; i < 256; i++) m_tab[i] = 18'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: reset state, R9: mask reset value
    host_read(4'h7);
    host_read(4'h8);
    host_read(4'h6);
    check("R9 mask pin after reset", pix_mask, 8'hFF);

    // R3: fill whole table with full-byte values; bits 7:6 must be dropped
    host_write(4'h8, 8'h00);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) host_write(4'h9, 8'($urandom));
    // R5: index wrapped to 0 after entry 255
    check("R5 index wrap after fill", 8'(m_idx), 8'h00);
    host_read(4'h8);

    // R2/R5: read from 254 across the wrap, with status reads mid-entry (R7)
    host_write(4'h7, 8'hFE);
    host_read(4'h8);
    host_read(4'h9);
    host_read(4'h7);
    host_read(4'h8);
    host_read(4'h9);
    host_read(4'h9);
    for (int c = 0; c < 3; c++) host_read(4'h9);
    host_read(4'h8);

    // R4: all-ones write must read back with bits 7:6 zero
    host_write(4'h8, 8'h20);
    for (int c = 0; c < 3; c++) host_write(4'h9, 8'hFF);
    host_write(4'h7, 8'h20);
    for (int c = 0; c < 3; c++) host_read(4'h9);
    check("R4 top bits zero", host_rdata & 8'hC0, 8'h00);

    // R6: abort after two bytes, then full entry
    host_write(4'h8, 8'h10);
    host_write(4'h9, 8'h11);
    host_write(4'h9, 8'h22);
    host_write(4'h8, 8'h10);
    host_write(4'h9, 8'h2A);
    host_write(4'h9, 8'h15);
    host_write(4'h9, 8'h3C);
    host_write(4'h7, 8'h10);
    host_read(4'h9);
    check("R6 red after abort", {2'b00, m_st[0]}, 8'h2A);
    host_read(4'h9);
    host_read(4'h9);
    // R6: abort a read mid-entry by switching to write
    host_read(4'h9);
    host_write(4'h8, 8'h40);
    host_read(4'h7);

    // R10: data read in write direction, then data write in read direction
    host_read(4'h9);
    host_write(4'h9, 8'h01);
    host_read(4'h9);
    host_write(4'h9, 8'h02);
    host_write(4'h9, 8'h03);
    host_write(4'h7, 8'h40);
    host_write(4'h9, 8'h3F);
    host_read(4'h9);
    host_read(4'h9);
    host_read(4'h9);

    // R9: mask write and pin
    host_write(4'h6, 8'h5A);
    check("R9 mask pin after write", pix_mask, 8'h5A);
    host_read(4'h6);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 6)       host_write(4'h8, 8'($urandom));
      else if (r < 12) host_write(4'h7, 8'($urandom));
      else if (r < 15) begin
        host_write(4'h6, 8'($urandom));
        check("R9 mask pin", pix_mask, m_mask);
      end
      else if (r < 48) host_write(4'h9, 8'($urandom));
      else if (r < 88) host_read(4'h9);
      else if (r < 93) host_read(4'h7);
      else if (r < 98) host_read(4'h8);
      else             host_read(4'h6);
    end

    // R1: final write-index load and readback
    host_write(4'h8, 8'hC3);
    host_read(4'h8);
    host_read(4'h7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule